// File: doc/BRIEF.md
# Clause-Granular Quad Issue Scheduler

This block is the issue stage of a small multi-threaded shader core. Threads are grouped into quads, and each quad runs a program that the compiler has cut into clauses. The scheduler makes a choice only when no clause is running. It picks one ready quad by round-robin, latches that quad's clause header, and streams the clause's instructions to the single execution unit, one per cycle, with no stall and no preemption. When the clause ends, the quad's program counter moves on by the clause length, or it is loaded from a branch target if the header marks a branch. Only then can that quad be chosen again.

Long-latency work, such as memory loads, is tracked per quad in a small set of dependency slots. A clause header can name one slot that the clause's request will occupy, and a mask of slots whose results must arrive before the clause may start. A completion pulse that carries a quad and a slot number frees the slot. A quad that waits on a busy slot is passed over, and other quads keep issuing. An external fetch stage presents the header found at each quad's current PC. The scheduler exports every quad's PC so that the fetch stage can do this.

Top module: `clause_sched`

## Requirements
- R1: While reset is held and after it is released, no instruction issues, no slot request is driven, every quad PC is 0 and no slot is busy. The first round-robin search starts at quad 0.
- R2: A granted clause issues exactly hdrLen+1 instructions (field value 0..7 gives a length of 1..8) on consecutive cycles. issueQuad stays constant, issuePc equals the clause's start PC plus the instruction index, and issueLast is high on the final instruction only.
- R3: A quad is chosen only between clauses. The cycle after a clause's last instruction issues nothing. If a quad is ready in that cycle, its clause starts on the next cycle.
- R4: A quad's PC does not change while its clause runs. When a clause ends, the PC becomes the old PC plus the length. If the header's branch flag is set, the PC becomes instead the value of branchTarget in the cycle where issueLast is high. A quad's clauses therefore issue in program order.
- R5: Among ready quads, the grant goes to the first one found when searching upward, with wrap-around, from the quad after the one granted last.
- R6: When the header's set-enable bit is 1, setValid pulses for one cycle together with the clause's first instruction, carrying setQuad and setSlot. From then on, that slot of that quad is busy.
- R7: A quad is not ready while any slot whose bit is 1 in its wait mask (bit i means slot i) is busy. A completion pulse in cycle t frees the slot, and the quad can be chosen from cycle t+1 on. Other quads keep issuing while it waits.
- R8: A busy slot that is not in a quad's wait mask does not hold that quad back.
- R9: A quad whose hdrValid is low is never chosen, and its PC does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hdrValid | input | NUM_QUADS | Header present at each quad's current PC |
| hdrLen | input | NUM_QUADS*LEN_W | Per-quad clause length minus one |
| hdrWait | input | NUM_QUADS*NUM_SLOTS | Per-quad wait mask, bit i = slot i |
| hdrSetEn | input | NUM_QUADS | Per-quad: clause occupies a slot |
| hdrSetSlot | input | NUM_QUADS*log2(NUM_SLOTS) | Per-quad slot to occupy |
| hdrBranch | input | NUM_QUADS | Per-quad: clause ends in a branch |
| doneValid | input | 1 | Completion pulse |
| doneQuad | input | log2(NUM_QUADS) | Quad of the completion |
| doneSlot | input | log2(NUM_SLOTS) | Slot freed by the completion |
| branchTarget | input | PC_W | Branch destination, sampled on the last instruction |
| quadPc | output | NUM_QUADS*PC_W | Current PC of every quad |
| issueValid | output | 1 | Instruction issued this cycle |
| issueQuad | output | log2(NUM_QUADS) | Quad owning the issued instruction |
| issuePc | output | PC_W | Address of the issued instruction |
| issueLast | output | 1 | Final instruction of the clause |
| setValid | output | 1 | Slot request driven this cycle |
| setQuad | output | log2(NUM_QUADS) | Quad of the slot request |
| setSlot | output | log2(NUM_SLOTS) | Slot of the slot request |

## Verification
The assertions take for granted that a quad's hdrValid and header fields stay steady while that quad's clause runs. They also assume that completion pulses refer only to slots that are really busy and never coincide with a new request for the same slot. The stimulus holds each quad's header fixed for a whole scenario and fires each completion pulse once, for a slot that an earlier clause has occupied. It places one completion inside a running clause and one in the idle cycle between clauses, so that the one-cycle wake latency is pinned down exactly.

// File: rtl/clause_sched_pkg.sv
package clause_sched_pkg;
  // Strobes from the control to the datapath.
  typedef struct packed {
    logic grant;   // a clause is being granted this cycle
    logic finish;  // the running clause issues its last instruction
  } sched_strobe_t;
endpackage

// File: rtl/clause_rr_arbiter.sv
module clause_rr_arbiter #(
  parameter int NUM_REQ = 4
) (
  input  logic [NUM_REQ-1:0]         req,
  input  logic [$clog2(NUM_REQ)-1:0] lastIdx,
  output logic                       anyGnt,
  output logic [$clog2(NUM_REQ)-1:0] gntIdx
);
  localparam int IW = $clog2(NUM_REQ);

  // Walk from the farthest candidate to the nearest so the nearest wins.
  always_comb begin
    anyGnt = 1'b0;
    gntIdx = '0;
    for (int i = NUM_REQ; i >= 1; i--) begin
      int cand;
      cand = (int'(lastIdx) + i) % NUM_REQ;
      if (req[cand]) begin
        anyGnt = 1'b1;
        gntIdx = IW'(cand);
      end
    end
  end
endmodule

// File: rtl/clause_sched_ctrl.sv
module clause_sched_ctrl
  import clause_sched_pkg::*;
#(
  parameter int NUM_QUADS = 4,
  parameter int LEN_W     = 3
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NUM_QUADS-1:0]         readyVec,
  input  logic [LEN_W-1:0]             curLen,
  output sched_strobe_t                strobe,
  output logic [$clog2(NUM_QUADS)-1:0] grantQuad,
  output logic                         active,
  output logic [$clog2(NUM_QUADS)-1:0] curQuad,
  output logic [LEN_W-1:0]             idx
);
  localparam int QW = $clog2(NUM_QUADS);

  logic [QW-1:0] lastPtr;
  logic          anyReady;

  clause_rr_arbiter #(.NUM_REQ(NUM_QUADS)) u_arb (
    .req    (readyVec),
    .lastIdx(lastPtr),
    .anyGnt (anyReady),
    .gntIdx (grantQuad)
  );

  always_comb begin
    strobe.grant  = !active && anyReady;
    strobe.finish = active && (idx == curLen);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active  <= 1'b0;
      curQuad <= '0;
      idx     <= '0;
      lastPtr <= QW'(NUM_QUADS - 1);
    end else if (strobe.grant) begin
      active  <= 1'b1;
      curQuad <= grantQuad;
      idx     <= '0;
      lastPtr <= grantQuad;
    end else if (strobe.finish) begin
      active <= 1'b0;
    end else if (active) begin
      idx <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/clause_sched_dp.sv
module clause_sched_dp
  import clause_sched_pkg::*;
#(
  parameter int NUM_QUADS = 4,
  parameter int NUM_SLOTS = 4,
  parameter int PC_W      = 8,
  parameter int LEN_W     = 3
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  sched_strobe_t                          strobe,
  input  logic [$clog2(NUM_QUADS)-1:0]           grantQuad,
  input  logic                                   active,
  input  logic [$clog2(NUM_QUADS)-1:0]           curQuad,
  input  logic [LEN_W-1:0]                       idx,
  input  logic [NUM_QUADS-1:0]                   hdrValid,
  input  logic [NUM_QUADS*LEN_W-1:0]             hdrLen,
  input  logic [NUM_QUADS*NUM_SLOTS-1:0]         hdrWait,
  input  logic [NUM_QUADS-1:0]                   hdrSetEn,
  input  logic [NUM_QUADS*$clog2(NUM_SLOTS)-1:0] hdrSetSlot,
  input  logic [NUM_QUADS-1:0]                   hdrBranch,
  input  logic                                   doneValid,
  input  logic [$clog2(NUM_QUADS)-1:0]           doneQuad,
  input  logic [$clog2(NUM_SLOTS)-1:0]           doneSlot,
  input  logic [PC_W-1:0]                        branchTarget,
  output logic [NUM_QUADS-1:0]                   readyVec,
  output logic [LEN_W-1:0]                       curLen,
  output logic [NUM_QUADS*PC_W-1:0]              quadPc,
  output logic [PC_W-1:0]                        issuePc,
  output logic                                   setValid,
  output logic [$clog2(NUM_SLOTS)-1:0]           setSlot
);
  localparam int SW = $clog2(NUM_SLOTS);

  logic [PC_W-1:0]      pcReg   [NUM_QUADS];
  logic [NUM_SLOTS-1:0] pendReg [NUM_QUADS];
  logic [LEN_W-1:0]     lenArr  [NUM_QUADS];
  logic [NUM_SLOTS-1:0] waitArr [NUM_QUADS];
  logic [SW-1:0]        slotArr [NUM_QUADS];
  logic                 curBranch;
  logic                 curSetEn;

  for (genvar q = 0; q < NUM_QUADS; q++) begin : g_quad
    assign lenArr[q]                  = hdrLen[q*LEN_W +: LEN_W];
    assign waitArr[q]                 = hdrWait[q*NUM_SLOTS +: NUM_SLOTS];
    assign slotArr[q]                 = hdrSetSlot[q*SW +: SW];
    assign readyVec[q]                = hdrValid[q] && ((pendReg[q] & waitArr[q]) == '0);
    assign quadPc[q*PC_W +: PC_W]     = pcReg[q];
  end

  assign issuePc  = pcReg[curQuad] + PC_W'(idx);
  assign setValid = active && (idx == '0) && curSetEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int q = 0; q < NUM_QUADS; q++) begin
        pcReg[q]   <= '0;
        pendReg[q] <= '0;
      end
      curLen    <= '0;
      curBranch <= 1'b0;
      curSetEn  <= 1'b0;
      setSlot   <= '0;
    end else begin
      if (doneValid) pendReg[doneQuad][doneSlot] <= 1'b0;
      if (strobe.grant) begin
        curLen    <= lenArr[grantQuad];
        curBranch <= hdrBranch[grantQuad];
        curSetEn  <= hdrSetEn[grantQuad];
        setSlot   <= slotArr[grantQuad];
        if (hdrSetEn[grantQuad]) pendReg[grantQuad][slotArr[grantQuad]] <= 1'b1;
      end
      if (strobe.finish)
        pcReg[curQuad] <= curBranch ? branchTarget
                                    : pcReg[curQuad] + PC_W'(curLen) + PC_W'(1);
    end
  end
endmodule

// File: rtl/clause_sched.sv
module clause_sched
  import clause_sched_pkg::*;
#(
  parameter int NUM_QUADS = 4,
  parameter int NUM_SLOTS = 4,
  parameter int PC_W      = 8,
  parameter int LEN_W     = 3
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  logic [NUM_QUADS-1:0]                   hdrValid,
  input  logic [NUM_QUADS*LEN_W-1:0]             hdrLen,
  input  logic [NUM_QUADS*NUM_SLOTS-1:0]         hdrWait,
  input  logic [NUM_QUADS-1:0]                   hdrSetEn,
  input  logic [NUM_QUADS*$clog2(NUM_SLOTS)-1:0] hdrSetSlot,
  input  logic [NUM_QUADS-1:0]                   hdrBranch,
  input  logic                                   doneValid,
  input  logic [$clog2(NUM_QUADS)-1:0]           doneQuad,
  input  logic [$clog2(NUM_SLOTS)-1:0]           doneSlot,
  input  logic [PC_W-1:0]                        branchTarget,
  output logic [NUM_QUADS*PC_W-1:0]              quadPc,
  output logic                                   issueValid,
  output logic [$clog2(NUM_QUADS)-1:0]           issueQuad,
  output logic [PC_W-1:0]                        issuePc,
  output logic                                   issueLast,
  output logic                                   setValid,
  output logic [$clog2(NUM_QUADS)-1:0]           setQuad,
  output logic [$clog2(NUM_SLOTS)-1:0]           setSlot
);
  localparam int QW = $clog2(NUM_QUADS);

  sched_strobe_t          strobe;
  logic [QW-1:0]          grantQuad;
  logic                   active;
  logic [QW-1:0]          curQuad;
  logic [LEN_W-1:0]       idx;
  logic [NUM_QUADS-1:0]   readyVec;
  logic [LEN_W-1:0]       curLen;

  clause_sched_ctrl #(.NUM_QUADS(NUM_QUADS), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .readyVec(readyVec), .curLen(curLen),
    .strobe(strobe), .grantQuad(grantQuad), .active(active),
    .curQuad(curQuad), .idx(idx)
  );

  clause_sched_dp #(
    .NUM_QUADS(NUM_QUADS), .NUM_SLOTS(NUM_SLOTS), .PC_W(PC_W), .LEN_W(LEN_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .grantQuad(grantQuad),
    .active(active), .curQuad(curQuad), .idx(idx),
    .hdrValid(hdrValid), .hdrLen(hdrLen), .hdrWait(hdrWait),
    .hdrSetEn(hdrSetEn), .hdrSetSlot(hdrSetSlot), .hdrBranch(hdrBranch),
    .doneValid(doneValid), .doneQuad(doneQuad), .doneSlot(doneSlot),
    .branchTarget(branchTarget), .readyVec(readyVec), .curLen(curLen),
    .quadPc(quadPc), .issuePc(issuePc), .setValid(setValid), .setSlot(setSlot)
  );

  assign issueValid = active;
  assign issueQuad  = curQuad;
  assign issueLast  = strobe.finish;
  assign setQuad    = curQuad;
endmodule

// File: rtl/clause_sched_checks.sv
module clause_sched_checks #(
  parameter int NUM_QUADS = 4,
  parameter int PC_W      = 8
) (
  input logic                         clk,
  input logic                         rstN,
  input logic [NUM_QUADS-1:0]         hdrValid,
  input logic [NUM_QUADS*PC_W-1:0]    quadPc,
  input logic                         issueValid,
  input logic [$clog2(NUM_QUADS)-1:0] issueQuad,
  input logic [PC_W-1:0]              issuePc,
  input logic                         issueLast,
  input logic                         setValid
);
  logic [PC_W-1:0] nextPc;
  logic [PC_W-1:0] ownPc;
  assign nextPc = issuePc + 1'b1;
  assign ownPc  = quadPc[issueQuad*PC_W +: PC_W];

  assert_contiguous_R2: assert property (@(posedge clk) disable iff (!rstN)
    issueValid && !issueLast |=> issueValid && issueQuad == $past(issueQuad)
                                 && issuePc == $past(nextPc));

  assert_idle_gap_R3: assert property (@(posedge clk) disable iff (!rstN)
    issueLast |=> !issueValid);

  assert_pc_frozen_R4: assert property (@(posedge clk) disable iff (!rstN)
    issueValid && !issueLast |=> $stable(ownPc));

  assert_request_with_issue_R6: assert property (@(posedge clk) disable iff (!rstN)
    setValid |-> issueValid);

  assert_request_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    setValid |=> !setValid);

  assert_valid_header_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(issueValid) |-> ((($past(hdrValid)) >> issueQuad) & 1'b1) != '0);
endmodule

bind clause_sched clause_sched_checks #(.NUM_QUADS(NUM_QUADS), .PC_W(PC_W)) u_checks (
  .clk(clk), .rstN(rstN), .hdrValid(hdrValid), .quadPc(quadPc),
  .issueValid(issueValid), .issueQuad(issueQuad), .issuePc(issuePc),
  .issueLast(issueLast), .setValid(setValid)
);

// File: tb/clause_sched_bench.sv
module clause_sched_bench;
  localparam int NQ = 4, NS = 4, PW = 8, LW = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic [NQ-1:0]    hdrValid, hdrSetEn, hdrBranch;
  logic [NQ*LW-1:0] hdrLen;
  logic [NQ*NS-1:0] hdrWait;
  logic [NQ*2-1:0]  hdrSetSlot;
  logic             doneValid = 1'b0;
  logic [1:0]       doneQuad = '0, doneSlot = '0;
  logic [PW-1:0]    branchTarget = 8'h40;
  logic [NQ*PW-1:0] quadPc;
  logic             issueValid, issueLast, setValid;
  logic [1:0]       issueQuad, setQuad, setSlot;
  logic [PW-1:0]    issuePc;

  logic [LW-1:0] cfgLen [NQ];
  logic [NS-1:0] cfgWait [NQ];
  logic [1:0]    cfgSlot [NQ];
  logic [NQ-1:0] cfgValid = '0, cfgSetEn = '0, cfgBranch = '0;

  always_comb begin
    hdrValid  = cfgValid;
    hdrSetEn  = cfgSetEn;
    hdrBranch = cfgBranch;
    for (int q = 0; q < NQ; q++) begin
      hdrLen[q*LW +: LW]  = cfgLen[q];
      hdrWait[q*NS +: NS] = cfgWait[q];
      hdrSetSlot[q*2 +: 2] = cfgSlot[q];
    end
  end

  clause_sched u_clause_sched (
    .clk(clk), .rstN(rstN), .hdrValid(hdrValid), .hdrLen(hdrLen),
    .hdrWait(hdrWait), .hdrSetEn(hdrSetEn), .hdrSetSlot(hdrSetSlot),
    .hdrBranch(hdrBranch), .doneValid(doneValid), .doneQuad(doneQuad),
    .doneSlot(doneSlot), .branchTarget(branchTarget), .quadPc(quadPc),
    .issueValid(issueValid), .issueQuad(issueQuad), .issuePc(issuePc),
    .issueLast(issueLast), .setValid(setValid), .setQuad(setQuad),
    .setSlot(setSlot)
  );

  int tests = 0;
  int fails = 0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clearCfg();
    cfgValid = '0; cfgSetEn = '0; cfgBranch = '0;
    for (int q = 0; q < NQ; q++) begin
      cfgLen[q] = '0; cfgWait[q] = '0; cfgSlot[q] = '0;
    end
  endtask

  task automatic resetDut();
    rstN = 1'b0;
    doneValid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic waitFirst();
    for (int n = 0; n < 20 && !issueValid; n++) @(negedge clk);
  endtask

  // Called at the falling edge of the cycle in which the clause must start.
  // pulseIdx: instruction index for a completion pulse, len = idle cycle, -1 none.
  task automatic expectClause(input int q, input int pc, input int lenField,
                              input bit setEn, input int slot, input int pulseIdx,
                              input int pq, input int ps);
    int len;
    len = lenField + 1;
    doneQuad = 2'(pq);
    doneSlot = 2'(ps);
    for (int k = 0; k < len; k++) begin
      doneValid = (k == pulseIdx);
      chk("R2", "issueValid", 32'(issueValid), 1);
      chk("R2", "issueQuad", 32'(issueQuad), 32'(q));
      chk("R2", "issuePc", 32'(issuePc), 32'((pc + k) & 8'hFF));
      chk("R2", "issueLast", 32'(issueLast), 32'(k == len - 1));
      chk("R4", "pc frozen", 32'(quadPc[q*PW +: PW]), 32'(pc));
      chk("R6", "setValid", 32'(setValid), 32'(k == 0 && setEn));
      if (k == 0 && setEn) begin
        chk("R6", "setQuad", 32'(setQuad), 32'(q));
        chk("R6", "setSlot", 32'(setSlot), 32'(slot));
      end
      @(negedge clk);
    end
    doneValid = (pulseIdx == len);
    chk("R3", "idle between clauses", 32'(issueValid), 0);
    @(negedge clk);
    doneValid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int expPc [NQ];
    clearCfg();

    // R1 / R9: reset state, no header present means no issue.
    @(negedge clk);
    chk("R1", "issueValid in reset", 32'(issueValid), 0);
    resetDut();
    for (int c = 0; c < 6; c++) begin
      chk("R9", "no issue without header", 32'(issueValid), 0);
      chk("R1", "no request", 32'(setValid), 0);
      @(negedge clk);
    end
    chk("R1", "quadPc after reset", quadPc, 0);

    // R2/R3/R4/R5: all quads ready, lengths 1,4,8,3, three full rotations.
    clearCfg();
    cfgValid = 4'hF;
    cfgLen[0] = 3'd0; cfgLen[1] = 3'd3; cfgLen[2] = 3'd7; cfgLen[3] = 3'd2;
    resetDut();
    waitFirst();
    for (int q = 0; q < NQ; q++) expPc[q] = 0;
    for (int r = 0; r < 3; r++)
      for (int q = 0; q < NQ; q++) begin
        // R5: rotation from quad 0 (R1) in ascending order
        expectClause(q, expPc[q], int'(cfgLen[q]), 1'b0, 0, -1, 0, 0);
        expPc[q] += int'(cfgLen[q]) + 1;
      end

    // R4/R9: branch clause on quad 1, quads 0 and 3 absent.
    clearCfg();
    cfgValid = 4'b0110;
    cfgLen[1] = 3'd1; cfgBranch[1] = 1'b1;
    cfgLen[2] = 3'd0;
    resetDut();
    waitFirst();
    expectClause(1, 0,     1, 1'b0, 0, -1, 0, 0);
    expectClause(2, 0,     0, 1'b0, 0, -1, 0, 0);
    expectClause(1, 8'h40, 1, 1'b0, 0, -1, 0, 0);  // R4 branch taken
    expectClause(2, 1,     0, 1'b0, 0, -1, 0, 0);
    expectClause(1, 8'h40, 1, 1'b0, 0, -1, 0, 0);
    chk("R9", "absent quad0 pc", 32'(quadPc[0*PW +: PW]), 0);
    chk("R9", "absent quad3 pc", 32'(quadPc[3*PW +: PW]), 0);
    chk("R4", "branch pc loaded", 32'(quadPc[1*PW +: PW]), 32'h40);

    // R6/R7/R8: quad0 waits on its own slot 2; quad1 occupies slot 1, waits on slot 0.
    clearCfg();
    cfgValid = 4'b0011;
    cfgLen[0] = 3'd0; cfgSetEn[0] = 1'b1; cfgSlot[0] = 2'd2; cfgWait[0] = 4'b0100;
    cfgLen[1] = 3'd1; cfgSetEn[1] = 1'b1; cfgSlot[1] = 2'd1; cfgWait[1] = 4'b0001;
    resetDut();
    waitFirst();
    expectClause(0, 0, 0, 1'b1, 2, -1, 0, 2);
    expectClause(1, 0, 1, 1'b1, 1, -1, 0, 2);  // R7 other quad proceeds
    expectClause(1, 2, 1, 1'b1, 1,  0, 0, 2);  // R8 own busy slot 1 ignored; pulse frees q0
    expectClause(0, 1, 0, 1'b1, 2, -1, 0, 2);  // R7 woken quad chosen
    expectClause(1, 4, 1, 1'b1, 1,  2, 0, 2);  // pulse in idle cycle
    expectClause(1, 6, 1, 1'b1, 1, -1, 0, 2);  // R7 not yet eligible in pulse cycle
    expectClause(0, 2, 0, 1'b1, 2, -1, 0, 2);  // R7 eligible one cycle later

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule